// File: doc/BRIEF.md
# Bus Latency Timeout Monitor

This block measures how long a bus-master request has been waiting for a grant. When that wait reaches a limit that software programs, it raises an error. A free-running prescaler divides the crystal clock by two, so each unit of the limit is two crystal periods, or 0.1 µs with a 20 MHz crystal. The reset limit of 0x0600 (1536 units) therefore trips after 153.6 µs of waiting. A limit of zero turns the check off.

Software uses a small register port with two selectable words. Word 0 holds the 16-bit limit. Word 1 is the status word, whose bit 0 is the error flag. The limit can be changed only while the controller is stopped or suspended. The error flag is sticky and is cleared by writing a one to status bit 0. An interrupt request is derived from the flag using a mask input and a global enable input. After firing, the timeout stays quiet until the current request ends, whether by grant or by withdrawal, and a new one begins.

Top module: `bus_wait_monitor`

## Requirements
- R1: After the hardware reset `rst_n` or the synchronous `soft_rst`, the limit reads 0x0600 on word 0 (`reg_sel`=0), the error flag is 0, status word 1 reads 0, and `irq` is 0.
- R2: A wait is a cycle with `req_pending`=1 and `grant`=0. A tick occurs on every second `clk` edge, counted from reset. During an unbroken wait, `err_flag` rises on the edge of the tick that brings the count of wait ticks up to the limit.
- R3: While the limit is 0, no wait of any length sets `err_flag`.
- R4: A write to word 0 updates the limit only when `stop` or `suspend` is 1. At any other time the write is ignored and word 0 keeps its previous value. Holding `stop` high does not change the limit.
- R5: `soft_rst` restores the limit to 0x0600 and clears the error flag, the wait count and the prescaler.
- R6: Any cycle that is not a wait clears the wait count. The next wait then needs the full limit again.
- R7: The error flag stays set until a write to word 1 with data bit 0 = 1. If the flag is being set in the same cycle as such a write, the set wins. The timeout fires at most once per wait and re-arms only after the wait ends.
- R8: `irq` is 1 exactly when the error flag is 1, `err_mask` is 0 and `int_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| stop | input | 1 | Controller stopped |
| suspend | input | 1 | Controller suspended |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Selects word 0 (limit) or word 1 (status) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| req_pending | input | 1 | Bus-master request outstanding |
| grant | input | 1 | Bus granted |
| err_mask | input | 1 | Masks the error interrupt when 1 |
| int_enable | input | 1 | Global interrupt enable |
| err_flag | output | 1 | Sticky latency error |
| irq | output | 1 | Interrupt request |

## Verification
Waits longer than the limit show the exact trip edge and the two-clock tick spacing. Waits broken by grant pulses or by a dropped request, each shorter than the limit, separate a restarting counter from one that only pauses. Long waits that continue after the flag is cleared show whether the timeout re-arms within a single request. Limit writes made with and without stop or suspend, a zero limit, and a soft reset followed by a wait at the 0x0600 default cover the programming rules. Mask and enable combinations, applied while the flag is held, cover the interrupt qualification.

// File: rtl/bus_wait_monitor.sv
module bus_wait_monitor #(
  parameter int CNT_W = 16,
  parameter int PRESCALE = 2,
  parameter logic [CNT_W-1:0] LIMIT_RST = 'h0600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stop,
  input  logic             suspend,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             req_pending,
  input  logic             grant,
  input  logic             err_mask,
  input  logic             int_enable,
  output logic             err_flag,
  output logic             irq
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] limit_q, cnt_q;
  logic             fired_q, err_q;
  logic             tick, waiting, limit_on, at_end, fire, wr_limit, clr_err;

  assign tick     = (pre_q == PW'(PRESCALE - 1));
  assign waiting  = req_pending & ~grant;
  assign limit_on = |limit_q;
  assign at_end   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_q};
  assign fire     = waiting & tick & limit_on & ~fired_q & at_end;
  assign wr_limit = reg_wr & ~reg_sel & (stop | suspend);
  assign clr_err  = reg_wr & reg_sel & reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (soft_rst) pre_q <= '0;
    else if (tick)     pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= LIMIT_RST;
    else if (soft_rst) limit_q <= LIMIT_RST;
    else if (wr_limit) limit_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (soft_rst || !waiting) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (tick && limit_on && !fired_q) cnt_q <= cnt_q + 1'b1;
      if (fire) fired_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (soft_rst) err_q <= 1'b0;
    else if (fire)     err_q <= 1'b1;
    else if (clr_err)  err_q <= 1'b0;
  end

  assign err_flag  = err_q;
  assign irq       = err_q & ~err_mask & int_enable;
  assign reg_rdata = reg_sel ? {{(CNT_W-1){1'b0}}, err_q} : limit_q;

  generate
    if (PRESCALE > 1) begin : g_tick_chk
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (tick && !soft_rst) |=> !tick); // R2
    end
  endgenerate

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (limit_q == '0 && !err_q) |=> !err_q); // R3
  AST_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!stop && !suspend && !soft_rst) |=> limit_q == $past(limit_q)); // R4
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (limit_q == LIMIT_RST && !err_q && cnt_q == '0)); // R5
  AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !waiting |=> cnt_q == '0); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_q && !clr_err && !soft_rst) |=> err_q); // R7
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) (fired_q && waiting && !soft_rst && !$past(waiting)) |-> 1'b0); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> err_flag); // R8

endmodule

// File: tb/test_bus_wait_monitor.sv
module test_bus_wait_monitor;
  logic clk = 0, rst_n = 0, soft_rst = 0, stop = 0, suspend = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic req_pending = 0, grant = 0, err_mask = 0, int_enable = 0;
  logic err_flag, irq;

  bus_wait_monitor i_bus_wait_monitor (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .suspend(suspend),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_pending(req_pending), .grant(grant), .err_mask(err_mask), .int_enable(int_enable),
    .err_flag(err_flag), .irq(irq));

  always #10 clk = ~clk;

  int total = 0, bad = 0, m_phase = 0, m_cnt = 0, m_limit = 'h600;
  bit m_err = 0, m_fired = 0, started = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    bit w, t, f;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_limit = 'h600; m_err = 0; m_fired = 0;
    end else if (soft_rst) begin
      m_phase = 0; m_cnt = 0; m_limit = 'h600; m_err = 0; m_fired = 0;
    end else begin
      w = req_pending && !grant;
      t = (m_phase == 1);
      f = w && t && m_limit != 0 && !m_fired && (m_cnt + 1 >= m_limit);
      if (!w) begin m_cnt = 0; m_fired = 0; end
      else begin
        if (t && m_limit != 0 && !m_fired) m_cnt++;
        if (f) m_fired = 1;
      end
      if (f) m_err = 1;
      else if (reg_wr && reg_sel && reg_wdata[0]) m_err = 0;
      if (reg_wr && !reg_sel && (stop || suspend)) m_limit = reg_wdata;
      m_phase = t ? 0 : m_phase + 1;
    end
    started = 1;
  end

  always @(posedge clk) begin
    #2;
    if (started) begin
      bit ei;
      int er;
      ei = m_err && !err_mask && int_enable;
      er = reg_sel ? int'(m_err) : m_limit;
      total += 3;
      if (err_flag !== m_err) begin bad++; $display("FAIL %s err_flag actual=%0b expected=%0b t=%0t", cur_req, err_flag, m_err, $time); end
      if (irq !== ei) begin bad++; $display("FAIL %s irq actual=%0b expected=%0b t=%0t", cur_req, irq, ei, $time); end
      if (reg_rdata !== er[15:0]) begin bad++; $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", cur_req, reg_rdata, er[15:0], $time); end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_sel = 0;
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1;
        cur_req = "R1"; int_enable = 1; cyc(4); reg_sel = 1; cyc(2); reg_sel = 0;
        cur_req = "R4"; wr(0, 16'd5); cyc(2); stop = 1; cyc(10); wr(0, 16'd5); stop = 0; cyc(2);
        cur_req = "R2"; req_pending = 1; cyc(20); reg_sel = 1; cyc(2); reg_sel = 0;
        cur_req = "R8"; err_mask = 1; cyc(2); int_enable = 0; cyc(2); err_mask = 0; cyc(2); int_enable = 1; cyc(2);
        cur_req = "R7"; wr(1, 16'h0000); cyc(2); wr(1, 16'h0001); cyc(20);
        req_pending = 0; cyc(1); req_pending = 1; cyc(14); wr(1, 16'h0001);
        cur_req = "R6";
        for (int k = 0; k < 6; k++) begin cyc(7); grant = 1; cyc(1); grant = 0; end
        for (int k = 0; k < 6; k++) begin cyc(7); req_pending = 0; cyc(1); req_pending = 1; end
        req_pending = 0; cyc(2);
        cur_req = "R7"; stop = 1; wr(0, 16'd1); stop = 0; req_pending = 1;
        for (int k = 0; k < 4; k++) begin @(negedge clk); reg_wr = 1; reg_sel = 1; reg_wdata = 16'h1; end
        @(negedge clk); reg_wr = 0; reg_sel = 0; req_pending = 0; cyc(2);
        cur_req = "R3"; suspend = 1; wr(0, 16'd0); suspend = 0; wr(1, 16'h1); req_pending = 1; cyc(60); req_pending = 0;
        cur_req = "R4"; wr(0, 16'd9); cyc(2); suspend = 1; wr(0, 16'd8); suspend = 0;
        req_pending = 1; cyc(10); stop = 1; wr(0, 16'd2); stop = 0; cyc(6); req_pending = 0; wr(1, 16'h1);
        cur_req = "R5"; @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0; cyc(2); reg_sel = 1; cyc(2); reg_sel = 0;
        cur_req = "R2"; req_pending = 1; cyc(3200); req_pending = 0; cyc(4);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++; $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule